// File: doc/BRIEF.md
# Bus monitor and interrupt encoder

This block sits beside a 68000-style asynchronous bus and watches each cycle. It combines three interrupt sources into one priority level for the CPU. The sources are a level-sensitive request line from a peripheral controller and two raster timing events, vertical and horizontal sync. The block holds each raster event in a pending flag until the CPU runs the acknowledge cycle for that event's level.

The block also decodes the CPU-space acknowledge cycle that belongs to the peripheral controller and answers it with an active-low acknowledge strobe. The controller then supplies its own vector. A third part raises bus error in four cases: a write into the ROM window, a write to the eight-byte reset-vector alias at address zero, a user-mode access to the protected low system area, and a cycle that no device answers within 64 bus clocks. Address and bus-clock widths, the timeout length and all region bounds are parameters.

Top module: `cpu_bus_guard`

## Requirements
- R1: The level output carries 6 for a pending peripheral request (periph_irq_n_i low), 4 for a pending vertical sync event and 2 for a pending horizontal sync event. Bit 0 of the level is always 0, so levels 7, 5, 3 and 1 never appear.
- R2: When several sources are pending at once, the level output shows the highest of them. When none is pending it shows 0. The peripheral line acts on the output in the same cycle; a raster event shows one clock after the edge at which it is sampled.
- R3: Each raster event sets its pending flag on a rising edge of its input only; an input held high does not set it again. An acknowledge cycle for the event's level clears the flag: AS low, read (rw_i=1), fc_i=3'b111, with addr_i[3:1] equal to 4 for vertical sync or 2 for horizontal sync. If a rising edge and such a clear fall on the same clock, the flag ends up set.
- R4: A read with fc_i=3'b111 and addr_i[3:1]=6 while AS is low drives periph_iack_n_o low one clock later. The strobe goes high again one clock after AS rises. A write with the same codes, or an acknowledge cycle for any other level, leaves the strobe high.
- R5: A write anywhere in byte addresses E00000..E3FFFF drives berr_n_o low one clock after AS falls. A read of that window, or a write just above it, does not.
- R6: When fc_i[2] is 0 (user mode), an access to byte addresses 000008..0007FF drives berr_n_o low one clock after AS falls. The same access in supervisor mode (fc_i[2]=1) does not, and neither does a user access at 000800.
- R7: A write to byte addresses 000000..000007, which alias the reset vectors in ROM, drives berr_n_o low. A read of that range does not, in either mode.
- R8: While AS is low and DTACK stays high, berr_n_o goes low at the 64th clock edge of the cycle and is still high after the 63rd. A DTACK that arrives before the limit stops the count, so no bus error follows.
- R9: Once asserted, berr_n_o stays low until AS is negated and goes high one clock later. The cycle counter restarts from zero for the next cycle.
- R10: After reset the level is 0, and periph_iack_n_o and berr_n_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one period is one timeout cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW-1 (23) | Word address, bits AW-1..1 |
| fc_i | input | 3 | CPU function code; bit 2 high means supervisor |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low |
| dtack_n_i | input | 1 | Data transfer acknowledge, active low |
| periph_irq_n_i | input | 1 | Peripheral interrupt request, active low, level |
| vsync_evt_i | input | 1 | Vertical sync event, rising edge sets pending |
| hsync_evt_i | input | 1 | Horizontal sync event, rising edge sets pending |
| ipl_o | output | 3 | Encoded interrupt priority level |
| periph_iack_n_o | output | 1 | Acknowledge strobe to the peripheral, active low |
| berr_n_o | output | 1 | Bus error, active low |

## Verification
Several properties are checked by assertions on every clock. The level never has bit 0 set, and a live peripheral request always wins. A raster edge always leaves a nonzero level on the next cycle. Bus error is held while AS stays low and is dropped once AS rises, and the counter is zero after each negated strobe. The acknowledge strobe follows the decode and never answers a write. Other behaviour is shown only by the bench scenarios: the exact edge on which the timeout fires (63 versus 64), the region boundaries at E3FFFE/E40000 and 0007FE/000800, set-wins when an edge coincides with a clear, and the absence of re-latching while a sync input is held high.

// File: rtl/busguard_pkg.sv
package busguard_pkg;

  localparam int LVL_W    = 3;
  localparam int NUM_SYNC = 2;  // index 0: vertical, index 1: horizontal

  typedef logic [LVL_W-1:0] level_t;

  localparam level_t LVL_NONE   = 3'd0;
  localparam level_t LVL_HSYNC  = 3'd2;
  localparam level_t LVL_VSYNC  = 3'd4;
  localparam level_t LVL_PERIPH = 3'd6;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  function automatic level_t sync_level(input int idx);
    return (idx == 0) ? LVL_VSYNC : LVL_HSYNC;
  endfunction

endpackage

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import busguard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                periph_req_i,
  input  logic [NUM_SYNC-1:0] sync_evt_i,
  input  logic [NUM_SYNC-1:0] sync_clr_i,
  output level_t              level_o
);

  logic [NUM_SYNC-1:0] evt_q;
  logic [NUM_SYNC-1:0] pend_q;
  logic [NUM_SYNC-1:0] pend_d;

  // a new rising edge beats a clear on the same clock
  generate
    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_src
      assign pend_d[g] = (sync_evt_i[g] & ~evt_q[g]) | (pend_q[g] & ~sync_clr_i[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      pend_q <= '0;
    end else begin
      evt_q  <= sync_evt_i;
      pend_q <= pend_d;
    end
  end

  // lowest priority first, later matches override
  always_comb begin
    level_o = LVL_NONE;
    for (int i = NUM_SYNC - 1; i >= 0; i--) begin
      if (pend_q[i]) level_o = sync_level(i);
    end
    if (periph_req_i) level_o = LVL_PERIPH;
  end

  AST_PERIPH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    periph_req_i |-> level_o == LVL_PERIPH); // R2
  AST_VSYNC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_evt_i[0]) |=> level_o >= LVL_VSYNC); // R3
  AST_HSYNC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_evt_i[1]) |=> level_o != LVL_NONE); // R3
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !sync_clr_i[0]) |=> pend_q[0]); // R3

endmodule

// File: rtl/iack_decode.sv
module iack_decode
  import busguard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                as_n_i,
  input  logic                rw_i,
  input  logic [2:0]          fc_i,
  input  level_t              lvl_sel_i,
  output logic                periph_ack_o,
  output logic [NUM_SYNC-1:0] sync_clr_o
);

  logic ack_cyc;
  logic ack_d;
  logic ack_q;

  assign ack_cyc = !as_n_i && rw_i && (fc_i == FC_CPU_SPACE);
  assign ack_d   = ack_cyc && (lvl_sel_i == LVL_PERIPH);

  generate
    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_clr
      assign sync_clr_o[g] = ack_cyc && (lvl_sel_i == sync_level(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign periph_ack_o = ack_q;

  AST_IACK_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_i && rw_i && fc_i == 3'b111 && lvl_sel_i == 3'd6) |=> periph_ack_o); // R4
  AST_IACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_i |=> !periph_ack_o); // R4
  AST_IACK_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_i |=> !periph_ack_o); // R4

endmodule

// File: rtl/bus_err_watch.sv
module bus_err_watch #(
  parameter int              AW          = 24,
  parameter int              TIMEOUT_CYC = 64,
  parameter logic [AW-1:0]   ROM_BASE    = 'hE00000,
  parameter logic [AW-1:0]   ROM_LAST    = 'hE3FFFF,
  parameter logic [AW-1:0]   PROT_BASE   = 'h000008,
  parameter logic [AW-1:0]   PROT_END    = 'h000800,
  parameter logic [AW-1:0]   ALIAS_END   = 'h000008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:1] addr_i,
  input  logic [2:0]    fc_i,
  input  logic          rw_i,
  input  logic          as_n_i,
  input  logic          dtack_n_i,
  output logic          berr_o
);

  localparam int              CNT_W    = $clog2(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [AW-1:1]   ROM_LO   = ROM_BASE[AW-1:1];
  localparam logic [AW-1:1]   ROM_HI   = ROM_LAST[AW-1:1];
  localparam logic [AW-1:1]   PROT_LO  = PROT_BASE[AW-1:1];
  localparam logic [AW-1:1]   PROT_HI  = PROT_END[AW-1:1];
  localparam logic [AW-1:1]   ALIAS_HI = ALIAS_END[AW-1:1];

  logic             rom_wr, alias_wr, prot_user, fault, timeout, cnt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             berr_q, berr_d;

  assign rom_wr    = !rw_i && (addr_i >= ROM_LO) && (addr_i <= ROM_HI);
  assign alias_wr  = !rw_i && (addr_i < ALIAS_HI);
  assign prot_user = !fc_i[2] && (addr_i >= PROT_LO) && (addr_i < PROT_HI);
  assign fault     = rom_wr || alias_wr || prot_user;

  assign cnt_en  = !as_n_i && dtack_n_i && (cnt_q != CNT_LAST);
  assign timeout = !as_n_i && dtack_n_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (as_n_i)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  assign berr_d = !as_n_i && (berr_q || fault || timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      berr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      berr_q <= berr_d;
    end
  end

  assign berr_o = berr_q;

  AST_BERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_q && !as_n_i) |=> berr_o); // R9
  AST_BERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_i |=> !berr_o); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_i |=> cnt_q == '0); // R9
  AST_ROM_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_i && !rw_i && addr_i >= ROM_LO && addr_i <= ROM_HI) |=> berr_o); // R5
  AST_USER_LOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_i && !fc_i[2] && addr_i >= PROT_LO && addr_i < PROT_HI) |=> berr_o); // R6
  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_i && dtack_n_i && cnt_q == CNT_LAST) |=> berr_o); // R8

endmodule

// File: rtl/cpu_bus_guard.sv
module cpu_bus_guard
  import busguard_pkg::*;
#(
  parameter int            AW          = 24,
  parameter int            TIMEOUT_CYC = 64,
  parameter logic [AW-1:0] ROM_BASE    = 'hE00000,
  parameter logic [AW-1:0] ROM_LAST    = 'hE3FFFF,
  parameter logic [AW-1:0] PROT_BASE   = 'h000008,
  parameter logic [AW-1:0] PROT_END    = 'h000800,
  parameter logic [AW-1:0] ALIAS_END   = 'h000008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:1] addr_i,
  input  logic [2:0]    fc_i,
  input  logic          rw_i,
  input  logic          as_n_i,
  input  logic          dtack_n_i,
  input  logic          periph_irq_n_i,
  input  logic          vsync_evt_i,
  input  logic          hsync_evt_i,
  output logic [2:0]    ipl_o,
  output logic          periph_iack_n_o,
  output logic          berr_n_o
);

  logic                rst_meta_q, rst_sync_q;
  logic [NUM_SYNC-1:0] sync_evt, sync_clr;
  logic                periph_ack, berr;
  level_t              level;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign sync_evt = {hsync_evt_i, vsync_evt_i};

  irq_level_enc u_enc (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .periph_req_i (!periph_irq_n_i),
    .sync_evt_i   (sync_evt),
    .sync_clr_i   (sync_clr),
    .level_o      (level)
  );

  iack_decode u_ack (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .as_n_i       (as_n_i),
    .rw_i         (rw_i),
    .fc_i         (fc_i),
    .lvl_sel_i    (addr_i[3:1]),
    .periph_ack_o (periph_ack),
    .sync_clr_o   (sync_clr)
  );

  bus_err_watch #(
    .AW          (AW),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ROM_BASE    (ROM_BASE),
    .ROM_LAST    (ROM_LAST),
    .PROT_BASE   (PROT_BASE),
    .PROT_END    (PROT_END),
    .ALIAS_END   (ALIAS_END)
  ) u_berr (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .addr_i    (addr_i),
    .fc_i      (fc_i),
    .rw_i      (rw_i),
    .as_n_i    (as_n_i),
    .dtack_n_i (dtack_n_i),
    .berr_o    (berr)
  );

  assign ipl_o           = level;
  assign periph_iack_n_o = !periph_ack;
  assign berr_n_o        = !berr;

  AST_LEVEL_EVEN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ipl_o[0]); // R1

endmodule

// File: tb/sim_cpu_bus_guard.sv
module sim_cpu_bus_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:1] addr;
  logic [2:0]  fc;
  logic        rw, as_n, dtack_n, pirq_n, vs, hs;
  logic [2:0]  ipl;
  logic        iack_n, berr_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cpu_bus_guard u0 (
    .clk (clk), .rst_n (rst_n), .addr_i (addr), .fc_i (fc), .rw_i (rw),
    .as_n_i (as_n), .dtack_n_i (dtack_n), .periph_irq_n_i (pirq_n),
    .vsync_evt_i (vs), .hsync_evt_i (hs),
    .ipl_o (ipl), .periph_iack_n_o (iack_n), .berr_n_o (berr_n)
  );

  // {byte address, fc, rw, expected berr_n, expected iack_n, requirement}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {24'hE00000, 3'd5, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 ROM read allowed
    {24'hE00000, 3'd5, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 ROM write faults
    {24'hE3FFFE, 3'd5, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 last ROM word
    {24'hE40000, 3'd5, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 just above ROM
    {24'h000400, 3'd1, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 user read low area
    {24'h000008, 3'd1, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 user write first byte
    {24'h000800, 3'd1, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 user at bound
    {24'h000400, 3'd5, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 supervisor allowed
    {24'h0007FE, 3'd1, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 last protected word
    {24'h000004, 3'd1, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 vector read user
    {24'h000002, 3'd5, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 vector write
    {24'hFFFFFC, 3'd7, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 peripheral ack
    {24'hFFFFFC, 3'd7, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 write ignored
    {24'hFFFFF8, 3'd7, 1'b1, 1'b1, 1'b1, 4'd4}   // R4 other level
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_start(input logic [23:0] a, input logic [2:0] f, input logic r);
    addr = a[23:1];
    fc   = f;
    rw   = r;
    as_n = 1'b0;
  endtask

  task automatic bus_end();
    as_n = 1'b1;
    rw   = 1'b1;
    fc   = 3'd5;
    addr = 23'h080000;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dtack_n = 1'b1; pirq_n = 1'b1; vs = 1'b0; hs = 1'b0;
    bus_end();
    step(3);
    rst_n = 1'b1;
    step(3);

    chk("R10", "reset ipl", 32'(ipl), 0);
    chk("R10", "reset iack_n", 32'(iack_n), 1);
    chk("R10", "reset berr_n", 32'(berr_n), 1);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[3:0]);
      bus_start(v[33:10], v[9:7], v[6]);
      step(1);
      chk(tag, $sformatf("vec %0d berr_n", i), 32'(berr_n), 32'(v[5]));
      chk(tag, $sformatf("vec %0d iack_n", i), 32'(iack_n), 32'(v[4]));
      bus_end();
      step(1);
      chk("R9", $sformatf("vec %0d berr_n release", i), 32'(berr_n), 1);
      chk("R4", $sformatf("vec %0d iack_n release", i), 32'(iack_n), 1);
    end

    // interrupt levels and priority
    pirq_n = 1'b0; step(1);
    chk("R1", "peripheral level", 32'(ipl), 6);
    pirq_n = 1'b1; step(1);
    chk("R2", "idle level", 32'(ipl), 0);
    vs = 1'b1; step(1);
    chk("R1", "vsync level", 32'(ipl), 4);
    hs = 1'b1; step(1);
    chk("R2", "vsync over hsync", 32'(ipl), 4);
    hs = 1'b0;
    pirq_n = 1'b0; step(1);
    chk("R2", "peripheral over both", 32'(ipl), 6);
    pirq_n = 1'b1; step(1);
    chk("R2", "back to vsync", 32'(ipl), 4);

    bus_start(24'hFFFFF8, 3'd7, 1'b1); step(1);
    chk("R3", "vsync cleared by ack", 32'(ipl), 2);
    chk("R4", "no iack for level 4", 32'(iack_n), 1);
    bus_end(); step(2);
    chk("R3", "held vsync not relatched", 32'(ipl), 2);
    vs = 1'b0; step(1);
    vs = 1'b1; step(1);
    chk("R3", "new vsync edge", 32'(ipl), 4);

    bus_start(24'hFFFFF4, 3'd7, 1'b1); step(1);
    chk("R3", "hsync cleared, vsync stays", 32'(ipl), 4);
    bus_end(); step(1);
    bus_start(24'hFFFFF8, 3'd7, 1'b1); step(1);
    chk("R2", "nothing pending", 32'(ipl), 0);
    bus_end(); step(1);

    vs = 1'b0; step(1);
    bus_start(24'hFFFFF8, 3'd7, 1'b1); vs = 1'b1; step(1);
    chk("R3", "edge wins over clear", 32'(ipl), 4);
    bus_end(); step(1);
    bus_start(24'hFFFFF8, 3'd7, 1'b1); step(1);
    chk("R3", "later clear", 32'(ipl), 0);
    bus_end(); step(1);

    // timeout
    bus_start(24'h100000, 3'd5, 1'b1); step(63);
    chk("R8", "no error after 63", 32'(berr_n), 1);
    step(1);
    chk("R8", "error at 64", 32'(berr_n), 0);
    step(5);
    chk("R9", "error held", 32'(berr_n), 0);
    bus_end(); step(1);
    chk("R9", "error released", 32'(berr_n), 1);
    bus_start(24'h100000, 3'd5, 1'b1); step(63);
    chk("R9", "counter restarted", 32'(berr_n), 1);
    step(1);
    chk("R8", "second timeout", 32'(berr_n), 0);
    bus_end(); step(1);

    bus_start(24'h100000, 3'd5, 1'b1); step(10);
    dtack_n = 1'b0; step(100);
    chk("R8", "dtack prevents timeout", 32'(berr_n), 1);
    bus_end(); dtack_n = 1'b1; step(1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule